// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block controls one 16-pin general-purpose I/O port through a 32-bit register interface. Each pin can be an input, a software-driven output, a pin handed to an on-chip peripheral, or an analog pin. For each pin, software also chooses the output stage type, the edge speed and the pull resistor. A 4-bit field per pin selects which peripheral owns the pin when the pin is in peripheral mode. The block keeps the output data latch and synchronizes the pad levels into a readable input register. A write-only set/clear register changes single output bits without a read-modify-write sequence.

The bus is a plain single-cycle strobe. A write with `bus_sel` and `bus_we` high changes the register at that clock edge. A read returns its data on `bus_rdata` after the next edge. The per-pin pad controls come from a registered stage, so they follow a register change one cycle later. The block leaves pad electrical behaviour, analog switching and the peripherals themselves to the surrounding logic.

Top module: `gpio_port`

## Requirements
- R1: After reset, every configuration register and the output latch read zero, and no pad output enable is asserted.
- R2: The mode register gives pin n the field at bits [2n+1:2n]. The codes are 0 input, 1 output, 2 peripheral, 3 analog. A pin in output mode drives its output latch bit with its enable asserted.
- R3: A pad output enable is asserted only for a pin in output mode, or for a pin in peripheral mode.
- R4: In peripheral mode, a pin drives the peripheral's data and follows the peripheral's drive request. The 4-bit select of pins 0-7 is at bits [4(n%8)+3:4(n%8)] of offset 0x20, and the select of pins 8-15 is at the same positions of offset 0x24. All selects appear on `pad_af_sel` at bits [4n+3:4n].
- R5: A pin in analog mode never drives and has both pull controls off.
- R6: A write to the set/clear register at offset 0x18 does three things. Bit n (n = 0..15) set to 1 sets output bit n. Bit n+16 set to 1 clears output bit n. Output bits whose two register bits are both zero keep their value. The register reads as zero.
- R7: When a single set/clear write has both bit n and bit n+16 set, output bit n ends up 1.
- R8: The output type register at offset 0x04 holds one bit per pin: 0 push-pull, 1 open-drain. An open-drain pin driving 1 releases its output enable, and an open-drain pin driving 0 drives low.
- R9: The pull register at offset 0x0C has 2 bits per pin at [2n+1:2n]. Code 1 raises the pull-up control, code 2 raises the pull-down control, and codes 0 and 3 raise neither.
- R10: The speed register at offset 0x08 has 2 bits per pin at [2n+1:2n], and it appears unchanged on `pad_speed`.
- R11: The input register at offset 0x10 shows the pad levels after two synchronizer flops. A read issued in either of the first two cycles after a pad change still returns the old level. A read issued in the third cycle returns the new level.
- R12: A read from the lock offset 0x1C, from any offset above 0x24 or from an unaligned address returns zero. A write to any of these addresses changes no register.
- R13: Mode (0x00), type, speed, pull, output data (0x14) and both select registers read back the value last written, with the unused upper bits of the 16-bit registers reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the edge that takes the read |
| pad_in | input | 16 | Pad levels, asynchronous |
| periph_out | input | 16 | Peripheral data per pin |
| periph_oe | input | 16 | Peripheral drive request per pin |
| pad_out | output | 16 | Value driven toward each pad |
| pad_oe | output | 16 | Per-pin output enable |
| pad_od | output | 16 | Per-pin open-drain flag |
| pad_pull_up | output | 16 | Per-pin pull-up control |
| pad_pull_dn | output | 16 | Per-pin pull-down control |
| pad_speed | output | 32 | Per-pin speed code, 2 bits each |
| pad_af_sel | output | 64 | Per-pin peripheral select, 4 bits each |

## Verification
The hardest case to reach is the synchronizer latency. Its effect shows only as a read that comes too early, so the bench changes `pad_in` and then issues three back-to-back reads of the input register. The first two reads must return the old level and the third the new one. A second hard case is a set/clear write that sets and clears the same bit in one access. The bench also checks that an open-drain pin releases its enable only when its output bit is 1: it flips that bit through the set/clear register and checks the enable after each write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int NPIN   = 16;
  localparam int DW     = 32;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int FLD2_W = 2 * NPIN;
  localparam int ALT_W  = 4 * NPIN;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IDX_MODE   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_OTYPE  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_SPEED  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_PULL   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_IN     = 4'd4;
  localparam logic [IDX_W-1:0] IDX_OUT    = 4'd5;
  localparam logic [IDX_W-1:0] IDX_SETCLR = 4'd6;
  localparam logic [IDX_W-1:0] IDX_LOCK   = 4'd7;
  localparam logic [IDX_W-1:0] IDX_ALTLO  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_ALTHI  = 4'd9;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_PERIPH = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    PL_NONE = 2'd0,
    PL_UP   = 2'd1,
    PL_DOWN = 2'd2,
    PL_RSVD = 2'd3
  } pull_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int N  = NPIN,
  parameter int AW = ADDR_W,
  parameter int W  = DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [N-1:0]      idr_i,
  output logic [W-1:0]      bus_rdata,
  output logic [2*N-1:0]    mode_q,
  output logic [N-1:0]      otype_q,
  output logic [2*N-1:0]    speed_q,
  output logic [2*N-1:0]    pull_q,
  output logic [N-1:0]      odr_q,
  output logic [4*N-1:0]    alt_q
);
  localparam int HALF = 2 * N;

  logic [AW-3:0] idx;
  logic          aligned;
  logic          wr_hit;
  logic [W-1:0]  rd_word;

  assign idx     = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_sel & bus_we & aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
      alt_q   <= '0;
    end else if (wr_hit) begin
      case (idx)
        IDX_MODE:   mode_q  <= bus_wdata[2*N-1:0];
        IDX_OTYPE:  otype_q <= bus_wdata[N-1:0];
        IDX_SPEED:  speed_q <= bus_wdata[2*N-1:0];
        IDX_PULL:   pull_q  <= bus_wdata[2*N-1:0];
        IDX_OUT:    odr_q   <= bus_wdata[N-1:0];
        // set half is ORed in last, so it wins over the clear half
        IDX_SETCLR: odr_q   <= (odr_q & ~bus_wdata[2*N-1:N]) | bus_wdata[N-1:0];
        IDX_ALTLO:  alt_q[HALF-1:0]     <= bus_wdata[HALF-1:0];
        IDX_ALTHI:  alt_q[2*HALF-1:HALF] <= bus_wdata[HALF-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_MODE:  rd_word = W'(mode_q);
      IDX_OTYPE: rd_word = W'(otype_q);
      IDX_SPEED: rd_word = W'(speed_q);
      IDX_PULL:  rd_word = W'(pull_q);
      IDX_IN:    rd_word = W'(idr_i);
      IDX_OUT:   rd_word = W'(odr_q);
      IDX_ALTLO: rd_word = W'(alt_q[HALF-1:0]);
      IDX_ALTHI: rd_word = W'(alt_q[2*HALF-1:HALF]);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      bus_rdata <= aligned ? rd_word : '0;
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter int N = NPIN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] mode_q,
  input  logic [N-1:0]   otype_q,
  input  logic [2*N-1:0] speed_q,
  input  logic [2*N-1:0] pull_q,
  input  logic [N-1:0]   odr_q,
  input  logic [4*N-1:0] alt_q,
  input  logic [N-1:0]   periph_out,
  input  logic [N-1:0]   periph_oe,
  output logic [N-1:0]   pad_out,
  output logic [N-1:0]   pad_oe,
  output logic [N-1:0]   pad_od,
  output logic [N-1:0]   pad_pull_up,
  output logic [N-1:0]   pad_pull_dn,
  output logic [2*N-1:0] pad_speed,
  output logic [4*N-1:0] pad_af_sel
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    pin_mode_e mode;
    pull_e     pull;
    logic      drv_val;
    logic      want_drive;

    always_comb begin
      mode       = pin_mode_e'(mode_q[2*i +: 2]);
      pull       = pull_e'(pull_q[2*i +: 2]);
      drv_val    = (mode == PM_PERIPH) ? periph_out[i] : odr_q[i];
      want_drive = (mode == PM_OUTPUT) || ((mode == PM_PERIPH) && periph_oe[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i]     <= 1'b0;
        pad_oe[i]      <= 1'b0;
        pad_od[i]      <= 1'b0;
        pad_pull_up[i] <= 1'b0;
        pad_pull_dn[i] <= 1'b0;
      end else begin
        pad_out[i]     <= drv_val;
        pad_oe[i]      <= want_drive && (!otype_q[i] || !drv_val);
        pad_od[i]      <= otype_q[i];
        pad_pull_up[i] <= (mode != PM_ANALOG) && (pull == PL_UP);
        pad_pull_dn[i] <= (mode != PM_ANALOG) && (pull == PL_DOWN);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_speed  <= '0;
      pad_af_sel <= '0;
    end else begin
      pad_speed  <= speed_q;
      pad_af_sel <= alt_q;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [NPIN-1:0]   periph_out,
  input  logic [NPIN-1:0]   periph_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_od,
  output logic [NPIN-1:0]   pad_pull_up,
  output logic [NPIN-1:0]   pad_pull_dn,
  output logic [FLD2_W-1:0] pad_speed,
  output logic [ALT_W-1:0]  pad_af_sel
);
  logic [NPIN-1:0]   idr_q;
  logic [FLD2_W-1:0] mode_q;
  logic [NPIN-1:0]   otype_q;
  logic [FLD2_W-1:0] speed_q;
  logic [FLD2_W-1:0] pull_q;
  logic [NPIN-1:0]   odr_q;
  logic [ALT_W-1:0]  alt_q;

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_in),
    .sync_o  (idr_q)
  );

  gpio_cfg_regs #(.N(NPIN), .AW(ADDR_W), .W(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .idr_i     (idr_q),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .otype_q   (otype_q),
    .speed_q   (speed_q),
    .pull_q    (pull_q),
    .odr_q     (odr_q),
    .alt_q     (alt_q)
  );

  gpio_pin_drive #(.N(NPIN)) u_drive (
    .clk         (clk),
    .rst         (rst),
    .mode_q      (mode_q),
    .otype_q     (otype_q),
    .speed_q     (speed_q),
    .pull_q      (pull_q),
    .odr_q       (odr_q),
    .alt_q       (alt_q),
    .periph_out  (periph_out),
    .periph_oe   (periph_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_od      (pad_od),
    .pad_pull_up (pad_pull_up),
    .pad_pull_dn (pad_pull_dn),
    .pad_speed   (pad_speed),
    .pad_af_sel  (pad_af_sel)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_od,
  input logic [NPIN-1:0]   odr_q,
  input logic [FLD2_W-1:0] mode_q
);
  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             setclr_wr;
  logic             dead_rd;
  logic             setclr_rd;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign setclr_wr = bus_sel && bus_we && aligned && (idx == IDX_SETCLR);
  assign setclr_rd = bus_sel && !bus_we && aligned && (idx == IDX_SETCLR);
  assign dead_rd   = bus_sel && !bus_we &&
                     (!aligned || (idx == IDX_LOCK) || (idx > IDX_ALTHI));

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (odr_q == '0 && pad_oe == '0));

  assert_setbits_R7: assert property (@(posedge clk) disable iff (rst)
    setclr_wr |=> ((odr_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  assert_clrbits_R6: assert property (@(posedge clk) disable iff (rst)
    setclr_wr |=> ((odr_q & $past(bus_wdata[2*NPIN-1:NPIN]) & ~$past(bus_wdata[NPIN-1:0])) == '0));

  assert_setclr_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    setclr_rd |=> (bus_rdata == '0));

  assert_dead_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    dead_rd |=> (bus_rdata == '0));

  assert_opendrain_low_R8: assert property (@(posedge clk) disable iff (rst)
    ((pad_od & pad_oe & pad_out) == '0));

  for (genvar i = 0; i < NPIN; i++) begin : g_oe
    assert_oe_mode_R3: assert property (@(posedge clk) disable iff (rst)
      pad_oe[i] |-> ($past(mode_q[2*i +: 2]) == 2'd1 || $past(mode_q[2*i +: 2]) == 2'd2));
  end
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_od    (pad_od),
  .odr_q     (odr_q),
  .mode_q    (mode_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] periph_out = '0;
  logic [15:0] periph_oe = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pull_up, pad_pull_dn;
  logic [31:0] pad_speed;
  logic [63:0] pad_af_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_exp;
  string       mon_tag;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_speed(pad_speed), .pad_af_sel(pad_af_sel)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops one expected item per read the design takes
  always @(posedge clk) begin
    if (!rst && bus_sel && !bus_we) begin
      #1;
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 64'd1, 64'd0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check(mon_tag, {32'd0, bus_rdata}, {32'd0, mon_exp});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_rd(6'h00, 32'h0, "R1 mode reset");
    bus_rd(6'h04, 32'h0, "R1 type reset");
    bus_rd(6'h08, 32'h0, "R1 speed reset");
    bus_rd(6'h0C, 32'h0, "R1 pull reset");
    bus_rd(6'h14, 32'h0, "R1 out reset");
    bus_rd(6'h20, 32'h0, "R1 sel lo reset");
    bus_rd(6'h24, 32'h0, "R1 sel hi reset");
    check("R1 pad_oe reset", {48'd0, pad_oe}, 64'h0);

    // R2 pins 0-3 as outputs
    bus_wr(6'h00, 32'h0000_0055);
    bus_wr(6'h14, 32'h0000_000F);
    settle();
    check("R2 oe outputs", {48'd0, pad_oe}, 64'h000F);
    check("R2 out value", {48'd0, pad_out}, 64'h000F);
    bus_rd(6'h14, 32'h0000_000F, "R13 out readback");

    // R6 set pin4, clear pin0
    bus_wr(6'h18, 32'h0001_0010);
    bus_rd(6'h14, 32'h0000_001E, "R6 set/clear result");
    bus_rd(6'h18, 32'h0, "R6 setclr reads zero");
    settle();
    check("R6 pad_out", {48'd0, pad_out}, 64'h001E);

    // R7 same pin set and clear: set wins
    bus_wr(6'h18, 32'h0002_0002);
    bus_rd(6'h14, 32'h0000_001E, "R7 set wins");
    bus_wr(6'h18, 32'h0004_0000);
    bus_rd(6'h14, 32'h0000_001A, "R6 clear only pin2");

    // R8 open drain on pin1 (value 1 -> released)
    bus_wr(6'h04, 32'h0000_0002);
    settle();
    check("R8 od releases high", {48'd0, pad_oe}, 64'h000D);
    check("R8 od flag", {48'd0, pad_od}, 64'h0002);
    bus_wr(6'h18, 32'h0002_0000);
    settle();
    check("R8 od drives low", {48'd0, pad_oe}, 64'h000F);

    // R4 peripheral mode on pin8, selects on pins 7 and 8
    periph_oe = 16'h0100; periph_out = 16'h0100;
    bus_wr(6'h00, 32'h0002_0055);
    bus_wr(6'h24, 32'h0000_000B);
    bus_wr(6'h20, 32'h7000_0000);
    settle();
    check("R4 periph oe", {48'd0, pad_oe}, 64'h010F);
    check("R4 periph data", {48'd0, pad_out}, 64'h0118);
    check("R4 select layout", pad_af_sel, 64'h0000_000B_7000_0000);
    periph_oe = 16'h0000;
    settle();
    check("R4 periph release", {48'd0, pad_oe}, 64'h000F);

    // R5 / R9 analog pin9, pulls on pins 9,10,11,12
    periph_oe = 16'h0200;
    bus_wr(6'h00, 32'h000E_0055);
    bus_wr(6'h0C, 32'h01E4_0000);
    settle();
    check("R5 analog no drive", {48'd0, pad_oe}, 64'h000F);
    check("R9 pull up (R5 analog off)", {48'd0, pad_pull_up}, 64'h1000);
    check("R9 pull down", {48'd0, pad_pull_dn}, 64'h0400);
    bus_rd(6'h0C, 32'h01E4_0000, "R13 pull readback");
    periph_oe = 16'h0000;

    // R10 speed
    bus_wr(6'h08, 32'hC000_0001);
    settle();
    check("R10 speed out", {32'd0, pad_speed}, 64'hC000_0001);
    bus_rd(6'h08, 32'hC000_0001, "R13 speed readback");

    // R11 synchronizer latency: back-to-back reads
    pad_in = 16'hA5C3;
    bus_rd(6'h10, 32'h0, "R11 first read old");
    bus_rd(6'h10, 32'h0, "R11 second read old");
    bus_rd(6'h10, 32'h0000_A5C3, "R11 third read new");

    // R12 lock, unmapped and unaligned
    bus_wr(6'h1C, 32'hFFFF_FFFF);
    bus_rd(6'h1C, 32'h0, "R12 lock reads zero");
    bus_wr(6'h28, 32'hFFFF_FFFF);
    bus_rd(6'h28, 32'h0, "R12 unmapped reads zero");
    bus_wr(6'h15, 32'h0000_FFFF);
    bus_rd(6'h14, 32'h0000_0018, "R12 unaligned write ignored");
    bus_rd(6'h00, 32'h000E_0055, "R12 mode untouched");

    // R13 readback masking
    bus_wr(6'h04, 32'hFFFF_FFFF);
    bus_rd(6'h04, 32'h0000_FFFF, "R13 type masked");
    bus_wr(6'h14, 32'hFFFF_1234);
    bus_rd(6'h14, 32'h0000_1234, "R13 out masked");
    bus_rd(6'h24, 32'h0000_000B, "R13 sel hi readback");

    settle();
    if (exp_q.size() != 0) check("scoreboard leftover", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule